// File: doc/BRIEF.md
# Quarter-rate transmit lane serializer

This block sits between a slow fabric transmit clock and a fast serializer clock that runs four times as fast. On every rising edge of the slow clock it takes one 40-bit word. The word holds four lanes, and each lane has an 8-bit byte, a special-character flag and a force-negative-disparity flag. A small dual-clock FIFO with Gray-coded pointers carries the packed word into the fast domain. There the block sends one 10-bit lane symbol per fast cycle to a downstream 8b/10b encoder.

Both sideband bits of a lane travel inside the same FIFO entry as that lane's byte. After the clock-domain crossing and the width reduction they therefore still come out in the same symbol as the byte. Words that arrive while the FIFO is full are dropped. A reader that runs dry stops its valid output. Each of these two events leaves a sticky flag in its own clock domain.

Top module: `txq_serializer`

## Requirements
- R1: While the slow reset is released, every rising edge of `clk_s` captures `s_data`, `s_special` and `s_negdisp` together as one word, and words leave in the order they were captured.
- R2: A word leaves as four symbols on four consecutive fast cycles: lane 0 (`s_data[7:0]`) first, then lanes 1 and 2, and lane 3 (`s_data[31:24]`) last.
- R3: Each symbol is `{negdisp, special, byte}`. Bit 9 is the lane's force-negative-disparity flag, bit 8 is its special-character flag and bits 7:0 are its byte, all three taken from the same lane of the same word. The symbol holds steady for the cycle it is valid.
- R4: `f_valid` stays low after the fast reset until the first word has crossed the FIFO. With the slow clock at exactly one quarter of the fast rate, every captured word is delivered with no gap and no loss.
- R5: The FIFO holds 2**ADDR_W words (4 by default). Writing four words with no reads does not overflow. A capture while the FIFO is full is dropped and sets `s_overflow`, which stays set until the slow reset. Words already stored are still delivered intact.
- R6: If a word finishes and no further word is waiting, `f_valid` falls and `f_underflow` is set. `f_underflow` stays set until the fast reset. Waiting for the very first word never sets it.
- R7: While reset is applied, `f_valid`, `f_underflow` and `s_overflow` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Slow transmit clock |
| rst_s_n | input | 1 | Asynchronous active-low reset, slow domain |
| s_data | input | 32 | Four lane bytes, lane 0 in bits 7:0 |
| s_special | input | 4 | Special-character flag per lane |
| s_negdisp | input | 4 | Force-negative-disparity flag per lane |
| s_overflow | output | 1 | Sticky flag: a word was dropped because the FIFO was full (slow domain) |
| clk_f | input | 1 | Fast serializer clock, four times the slow rate |
| rst_f_n | input | 1 | Asynchronous active-low reset, fast domain |
| f_sym | output | 10 | Current lane symbol {negdisp, special, byte} |
| f_valid | output | 1 | `f_sym` holds a lane of a delivered word |
| f_underflow | output | 1 | Sticky flag: the reader ran out of words (fast domain) |

## Verification
The assertions check on every cycle the things that can be seen locally in time:
- the lane index steps by one inside a word, and a word starts at lane 0;
- the held word does not change until its fourth lane has gone out;
- a full FIFO at a capture edge raises the overflow flag, and an empty FIFO at a word boundary raises the underflow flag and drops valid;
- both flags are sticky.

Only the bench scenarios can show end-to-end properties:
- data integrity across the crossing, checked by sweeping every byte value through every lane;
- that no word is lost at the exact 4:1 rate;
- that the words dropped on overflow never appear at the output, while the four stored words do.

// File: rtl/txq_serializer.sv
module txq_serializer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                    clk_s,
  input  logic                    rst_s_n,
  input  logic [LANES*BYTE_W-1:0] s_data,
  input  logic [LANES-1:0]        s_special,
  input  logic [LANES-1:0]        s_negdisp,
  output logic                    s_overflow,
  input  logic                    clk_f,
  input  logic                    rst_f_n,
  output logic [BYTE_W+1:0]       f_sym,
  output logic                    f_valid,
  output logic                    f_underflow
);

  localparam int SYM_W  = BYTE_W + 2;
  localparam int WORD_W = LANES * SYM_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW     = ADDR_W + 1;
  localparam int LW     = $clog2(LANES);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [WORD_W-1:0] in_word;
  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign in_word[i*SYM_W +: SYM_W] = {s_negdisp[i], s_special[i], s_data[i*BYTE_W +: BYTE_W]};
  end

  // write side
  logic [PW-1:0] wbin, wgray, rgray_s1, rgray_s2, rgray;
  logic          full;
  logic [PW-1:0] wbin_nx;

  assign wbin_nx = wbin + PW'(1);
  assign full    = (wgray == {~rgray_s2[PW-1:PW-2], rgray_s2[PW-3:0]});

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      wbin       <= '0;
      wgray      <= '0;
      rgray_s1   <= '0;
      rgray_s2   <= '0;
      s_overflow <= 1'b0;
    end else begin
      rgray_s1 <= rgray;
      rgray_s2 <= rgray_s1;
      if (full) begin
        s_overflow <= 1'b1;
      end else begin
        wbin  <= wbin_nx;
        wgray <= to_gray(wbin_nx);
      end
    end
  end

  always_ff @(posedge clk_s) begin
    if (rst_s_n && !full) mem[wbin[ADDR_W-1:0]] <= in_word;
  end

  // read side
  logic [PW-1:0]     rbin, wgray_f1, wgray_f2;
  logic [PW-1:0]     rbin_nx;
  logic              empty, at_edge;
  logic [LW-1:0]     lane;
  logic [WORD_W-1:0] cur_word;

  assign rbin_nx = rbin + PW'(1);
  assign empty   = (rgray == wgray_f2);
  assign at_edge = !f_valid || (lane == LW'(LANES - 1));
  assign f_sym   = cur_word[lane*SYM_W +: SYM_W];

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      rbin        <= '0;
      rgray       <= '0;
      wgray_f1    <= '0;
      wgray_f2    <= '0;
      lane        <= '0;
      cur_word    <= '0;
      f_valid     <= 1'b0;
      f_underflow <= 1'b0;
    end else begin
      wgray_f1 <= wgray;
      wgray_f2 <= wgray_f1;
      if (at_edge) begin
        if (!empty) begin
          cur_word <= mem[rbin[ADDR_W-1:0]];
          rbin     <= rbin_nx;
          rgray    <= to_gray(rbin_nx);
          lane     <= '0;
          f_valid  <= 1'b1;
        end else begin
          if (f_valid) f_underflow <= 1'b1;
          f_valid <= 1'b0;
        end
      end else begin
        lane <= lane + LW'(1);
      end
    end
  end

endmodule

// File: rtl/txq_serializer_chk.sv
module txq_serializer_chk #(
  parameter int LANES  = 4,
  parameter int LW     = 2,
  parameter int WORD_W = 40
) (
  input logic              clk_s,
  input logic              rst_s_n,
  input logic              clk_f,
  input logic              rst_f_n,
  input logic              f_valid,
  input logic              f_underflow,
  input logic              s_overflow,
  input logic              full,
  input logic              empty,
  input logic [LW-1:0]     lane,
  input logic [WORD_W-1:0] cur_word
);

  p_lane_step_r2: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (f_valid && lane != LW'(LANES - 1)) |=> (f_valid && lane == $past(lane) + LW'(1)));

  p_word_start_r2: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    $rose(f_valid) |-> (lane == '0));

  p_word_hold_r3: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (f_valid && lane != LW'(LANES - 1)) |=> $stable(cur_word));

  p_underflow_set_r6: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (f_valid && lane == LW'(LANES - 1) && empty) |=> (f_underflow && !f_valid));

  p_underflow_sticky_r6: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    f_underflow |=> f_underflow);

  p_overflow_set_r5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    full |=> s_overflow);

  p_overflow_sticky_r5: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    s_overflow |=> s_overflow);

endmodule

bind txq_serializer txq_serializer_chk #(.LANES(LANES), .LW(LW), .WORD_W(WORD_W)) u_chk (
  .clk_s(clk_s), .rst_s_n(rst_s_n), .clk_f(clk_f), .rst_f_n(rst_f_n),
  .f_valid(f_valid), .f_underflow(f_underflow), .s_overflow(s_overflow),
  .full(full), .empty(empty), .lane(lane), .cur_word(cur_word)
);

// File: tb/sim_txq_serializer.sv
module sim_txq_serializer;

  logic        clk_s, rst_s_n, clk_f, rst_f_n;
  logic [31:0] s_data;
  logic [3:0]  s_special, s_negdisp;
  logic        s_overflow, f_valid, f_underflow;
  logic [9:0]  f_sym;

  int checks = 0, fails = 0;
  int widx = 0, nwr = 0, ridx = 0, rlane = 0;
  bit s_run = 1, wrote = 0;

  txq_serializer u0 (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .s_data(s_data), .s_special(s_special),
    .s_negdisp(s_negdisp), .s_overflow(s_overflow), .clk_f(clk_f), .rst_f_n(rst_f_n),
    .f_sym(f_sym), .f_valid(f_valid), .f_underflow(f_underflow)
  );

  function automatic logic [7:0] e_data(int n, int l);
    return 8'((n + 64 * l) & 255);
  endfunction
  function automatic logic e_spc(int n, int l);
    return 1'(((n >> (l + 1)) ^ n) & 1);
  endfunction
  function automatic logic e_nd(int n, int l);
    return ((n * 3 + l) % 5) == 0;
  endfunction
  function automatic logic [9:0] e_sym(int n, int l);
    return {e_nd(n, l), e_spc(n, l), e_data(n, l)};
  endfunction

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      s_data[i*8 +: 8] = e_data(widx, i);
      s_special[i]     = e_spc(widx, i);
      s_negdisp[i]     = e_nd(widx, i);
    end
  end

  initial begin
    clk_f = 0;
    forever #4 clk_f = ~clk_f;
  end

  initial begin
    clk_s = 0;
    #2;
    forever begin
      #16;
      if (s_run || clk_s) clk_s = ~clk_s;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk_s) wrote = rst_s_n;
  always @(negedge clk_s) if (wrote) begin widx++; nwr++; wrote = 0; end

  // symbol monitor: R1 order, R2 lane sequence, R3 field packing
  always @(negedge clk_f) begin
    if (rst_f_n && f_valid) begin
      chk(f_sym == e_sym(ridx, rlane), "R3", $sformatf("word %0d lane %0d symbol", ridx, rlane),
          int'(f_sym), int'(e_sym(ridx, rlane)));
      rlane++;
      if (rlane == 4) begin rlane = 0; ridx++; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_f);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1 (run completed)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_s_n = 0; rst_f_n = 0;
    repeat (5) @(negedge clk_f);
    chk(f_valid == 0, "R7", "f_valid in reset", f_valid, 0);
    chk(f_underflow == 0, "R7", "f_underflow in reset", f_underflow, 0);
    chk(s_overflow == 0, "R7", "s_overflow in reset", s_overflow, 0);

    // full sweep at matched rates
    rst_s_n = 1; rst_f_n = 1;
    repeat (2) @(negedge clk_f);
    chk(f_valid == 0, "R4", "f_valid before first word", f_valid, 0);
    wait (nwr == 256);
    s_run = 0;
    chk(f_underflow == 0, "R6", "no underflow while streaming", f_underflow, 0);
    chk(s_overflow == 0, "R5", "no overflow at matched rate", s_overflow, 0);
    repeat (40) @(negedge clk_f);
    chk(ridx == 256, "R4", "words delivered", ridx, 256);
    chk(rlane == 0, "R2", "lanes per word", rlane, 0);
    chk(nwr == 256, "R1", "words captured", nwr, 256);
    chk(f_valid == 0, "R6", "f_valid after drain", f_valid, 0);
    chk(f_underflow == 1, "R6", "f_underflow after drain", f_underflow, 1);

    // overflow with reader held in reset
    @(negedge clk_f);
    rst_s_n = 0; rst_f_n = 0;
    widx = 0; nwr = 0; ridx = 0; rlane = 0;
    s_run = 1;
    repeat (3) @(negedge clk_f);
    chk(f_underflow == 0, "R7", "f_underflow cleared by reset", f_underflow, 0);
    chk(s_overflow == 0, "R7", "s_overflow after reset", s_overflow, 0);
    rst_s_n = 1;
    wait (nwr == 4);
    chk(s_overflow == 0, "R5", "four writes fit", s_overflow, 0);
    wait (nwr == 8);
    s_run = 0;
    @(negedge clk_f);
    chk(s_overflow == 1, "R5", "overflow flag", s_overflow, 1);
    chk(f_valid == 0, "R4", "f_valid with reader in reset", f_valid, 0);
    rst_f_n = 1;
    repeat (60) @(negedge clk_f);
    chk(ridx == 4, "R5", "stored words delivered, dropped ones absent", ridx, 4);
    chk(f_underflow == 1, "R6", "underflow after draining stored words", f_underflow, 1);
    chk(f_valid == 0, "R6", "f_valid after drain", f_valid, 0);
    chk(s_overflow == 1, "R5", "overflow flag still set", s_overflow, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule